// File: doc/BRIEF.md
# Wall-Following Robot Steering Controller

This block is the steering brain of a small maze robot that keeps one wall at its side. Two touch antennae, one at the left and one at the right, report whether they are touching a wall. On every clock the controller samples both antenna bits and moves a two-bit state register between four behaviours. The four behaviours are: searching for a wall, turning away from an obstacle, hugging a wall it touches, and curving back toward a wall it has lost.

Three motion commands leave the block: step forward, turn slightly left and turn slightly right. They are decoded from the current state alone, so a change on the antennae reaches the motors only after the next clock edge. An asynchronous active-low reset puts the robot into the wall-search behaviour at once. The reset is released through a small synchronizer so that leaving reset is aligned to the clock.

Top module: `wallbot_ctrl`

## Requirements
- R1: While `rst_n` is low the state is search (code 00) and the outputs are forward=1, turn-left=0, turn-right=0. This takes effect without waiting for a clock edge. After `rst_n` rises, the state stays in search while both antennae read 0.
- R2: Each state drives one fixed output pattern {forward, turn-left, turn-right}. Search (code 00) drives 100. Veer-away (code 01) drives 010. Hug (code 10) drives 110. Seek (code 11) drives 101.
- R3: From search, the next state is search when left=0 and right=0. It is veer-away when either antenna reads 1.
- R4: From veer-away, the next state is seek when both antennae read 0. Otherwise it stays veer-away.
- R5: From hug, left=1 leads to veer-away. Left=0 with right=1 stays in hug. Both 0 leads to seek.
- R6: From seek, left=1 leads to veer-away. Left=0 with right=1 leads to hug. Both 0 stays in seek.
- R7: turn-left and turn-right are never 1 in the same cycle.
- R8: A change on the antenna inputs between clock edges leaves the outputs unchanged until the next rising edge (Moore behaviour).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ant_left | input | 1 | Left antenna, 1 when touching a wall |
| ant_right | input | 1 | Right antenna, 1 when touching a wall |
| mv_fwd | output | 1 | Step forward |
| mv_left | output | 1 | Turn slightly left |
| mv_right | output | 1 | Turn slightly right |

## Verification
The vector walk visits every state under each antenna pattern. The hardest cases are the ones where left=1 must override right.

A design that checked right before left in hug or seek would stay in hug, or go to hug, when it hits a wall in front. A design that gave right-only special treatment in veer-away would leave that state too early.

Each way out of search is reached from a fresh reset. A machine that ignored one antenna there would keep driving forward into the wall. The bench also moves the antennae between clock edges, which exposes output logic that looks at the inputs directly. Reset is asserted in the middle of a cycle, which exposes a reset that only acts on a clock edge.

// File: rtl/wallbot_pkg.sv
package wallbot_pkg;

  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_SEARCH = 2'b00,
    ST_VEER   = 2'b01,
    ST_HUG    = 2'b10,
    ST_SEEK   = 2'b11
  } wb_state_e;

  typedef struct packed {
    logic fwd;
    logic turn_l;
    logic turn_r;
  } wb_motion_t;

endpackage

// File: rtl/wallbot_rst_sync.sv
module wallbot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[LAST];
endmodule

// File: rtl/wallbot_next.sv
module wallbot_next
  import wallbot_pkg::*;
(
  input  wb_state_e state_i,
  input  logic      ant_l_i,
  input  logic      ant_r_i,
  output wb_state_e state_o
);
  always_comb begin
    state_o = state_i;
    unique case (state_i)
      ST_SEARCH: begin
        if (ant_l_i || ant_r_i) state_o = ST_VEER;
        else                    state_o = ST_SEARCH;
      end
      ST_VEER: begin
        if (!ant_l_i && !ant_r_i) state_o = ST_SEEK;
        else                      state_o = ST_VEER;
      end
      ST_HUG: begin
        if (ant_l_i)      state_o = ST_VEER;
        else if (ant_r_i) state_o = ST_HUG;
        else              state_o = ST_SEEK;
      end
      ST_SEEK: begin
        if (ant_l_i)      state_o = ST_VEER;
        else if (ant_r_i) state_o = ST_HUG;
        else              state_o = ST_SEEK;
      end
      default: state_o = ST_SEARCH;
    endcase
  end
endmodule

// File: rtl/wallbot_decode.sv
module wallbot_decode
  import wallbot_pkg::*;
(
  input  wb_state_e  state_i,
  output wb_motion_t motion_o
);
  always_comb begin
    motion_o = '{fwd: 1'b1, turn_l: 1'b0, turn_r: 1'b0};
    unique case (state_i)
      ST_SEARCH: motion_o = '{fwd: 1'b1, turn_l: 1'b0, turn_r: 1'b0};
      ST_VEER:   motion_o = '{fwd: 1'b0, turn_l: 1'b1, turn_r: 1'b0};
      ST_HUG:    motion_o = '{fwd: 1'b1, turn_l: 1'b1, turn_r: 1'b0};
      ST_SEEK:   motion_o = '{fwd: 1'b1, turn_l: 1'b0, turn_r: 1'b1};
      default:   motion_o = '{fwd: 1'b1, turn_l: 1'b0, turn_r: 1'b0};
    endcase
  end
endmodule

// File: rtl/wallbot_ctrl.sv
module wallbot_ctrl
  import wallbot_pkg::*;
#(
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ant_left,
  input  logic ant_right,
  output logic mv_fwd,
  output logic mv_left,
  output logic mv_right
);
  logic       rst_sync_n;
  logic       rst_any_n;
  wb_state_e  state_q;
  wb_state_e  state_d;
  wb_motion_t motion;

  wallbot_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Raw reset asserts immediately; release follows the synchronizer.
  assign rst_any_n = rst_n & rst_sync_n;

  wallbot_next u_next (
    .state_i (state_q),
    .ant_l_i (ant_left),
    .ant_r_i (ant_right),
    .state_o (state_d)
  );

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n) state_q <= ST_SEARCH;
    else            state_q <= state_d;
  end

  wallbot_decode u_decode (
    .state_i  (state_q),
    .motion_o (motion)
  );

  assign mv_fwd   = motion.fwd;
  assign mv_left  = motion.turn_l;
  assign mv_right = motion.turn_r;
endmodule

// File: rtl/wallbot_ctrl_chk.sv
module wallbot_ctrl_chk
  import wallbot_pkg::*;
(
  input logic      clk,
  input logic      rst_ni,
  input logic      ant_l,
  input logic      ant_r,
  input wb_state_e state,
  input logic      fwd,
  input logic      tl,
  input logic      tr
);
  a_r7_turn_exclusive: assert property (@(posedge clk) disable iff (!rst_ni)
    !(tl && tr));

  a_r2_search_out: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_SEARCH) |-> (fwd && !tl && !tr));

  a_r2_seek_out: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_SEEK) |-> (fwd && !tl && tr));

  a_r3_search_exit: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_SEARCH && (ant_l || ant_r)) |=> (state == ST_VEER));

  a_r4_veer_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_VEER && (ant_l || ant_r)) |=> (state == ST_VEER));

  a_r5_hug_left: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_HUG && ant_l) |=> (state == ST_VEER));

  a_r6_seek_right: assert property (@(posedge clk) disable iff (!rst_ni)
    (state == ST_SEEK && !ant_l && ant_r) |=> (state == ST_HUG));
endmodule

bind wallbot_ctrl wallbot_ctrl_chk u_chk (
  .clk    (clk),
  .rst_ni (rst_any_n),
  .ant_l  (ant_left),
  .ant_r  (ant_right),
  .state  (state_q),
  .fwd    (mv_fwd),
  .tl     (mv_left),
  .tr     (mv_right)
);

// File: tb/wallbot_ctrl_tb.sv
`timescale 1ns/1ps
module wallbot_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic ant_left, ant_right;
  logic mv_fwd, mv_left, mv_right;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  wallbot_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ant_left(ant_left), .ant_right(ant_right),
    .mv_fwd(mv_fwd), .mv_left(mv_left), .mv_right(mv_right)
  );

  // {left, right, exp_fwd, exp_turn_l, exp_turn_r}
  localparam int NV = 19;
  localparam logic [4:0] VEC [NV] = '{
    5'b00_100, 5'b01_010, 5'b01_010, 5'b10_010, 5'b00_101,
    5'b00_101, 5'b01_110, 5'b01_110, 5'b00_101, 5'b01_110,
    5'b10_010, 5'b11_010, 5'b00_101, 5'b11_010, 5'b00_101,
    5'b10_010, 5'b00_101, 5'b01_110, 5'b11_010
  };

  task automatic check_out(input logic [2:0] exp, input string req);
    n_checks++;
    if ({mv_fwd, mv_left, mv_right} !== exp) begin
      n_errors++;
      $display("FAIL %s: outputs=%b expected=%b at %0t", req,
               {mv_fwd, mv_left, mv_right}, exp, $time);
    end
  endtask

  // R7: turn outputs never both high, observed every cycle after reset.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      n_checks++;
      if (mv_left === 1'b1 && mv_right === 1'b1) begin
        n_errors++;
        $display("FAIL R7: turn_l=%b turn_r=%b expected not both 1",
                 mv_left, mv_right);
      end
    end
  end

  task automatic reset_and_release();
    @(negedge clk);
    ant_left = 1'b0; ant_right = 1'b0;
    rst_n = 1'b0;
    #1 check_out(3'b100, "R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out(3'b100, "R1 idle after release");
  endtask

  task automatic search_exit(input logic l, input logic r);
    reset_and_release();
    ant_left = l; ant_right = r;
    @(negedge clk);
    check_out(3'b010, "R3 search exit");
  endtask

  initial begin
    rst_n = 1'b0; ant_left = 1'b0; ant_right = 1'b0;
    repeat (3) @(negedge clk);
    check_out(3'b100, "R1 reset state");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out(3'b100, "R1 after release");

    // Vector walk (R2..R6), with mid-cycle stability check (R8)
    for (int i = 0; i < NV; i++) begin
      logic [2:0] prev;
      prev = {mv_fwd, mv_left, mv_right};
      ant_left = VEC[i][4]; ant_right = VEC[i][3];
      #1 check_out(prev, "R8 no change before edge");
      @(negedge clk);
      check_out(VEC[i][2:0], "R2-R6 vector");
    end

    // Directed: every way out of search (R3)
    search_exit(1'b0, 1'b1);
    search_exit(1'b1, 1'b0);
    search_exit(1'b1, 1'b1);

    // Directed: reset mid-cycle while in hug state (R1)
    reset_and_release();
    ant_left = 1'b0; ant_right = 1'b1; @(negedge clk);  // veer
    ant_left = 1'b0; ant_right = 1'b0; @(negedge clk);  // seek
    ant_left = 1'b0; ant_right = 1'b1; @(negedge clk);  // hug
    check_out(3'b110, "R5 reached hug");
    #1 rst_n = 1'b0;
    #0.5 check_out(3'b100, "R1 async mid-cycle");
    @(negedge clk);
    ant_left = 1'b0; ant_right = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_out(3'b100, "R1 search after mid reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule